// File: doc/BRIEF.md
# Memory Access Fault Checker

This block sits next to a load/store unit and watches every access it issues and every bus response it gets back. It performs three independent checks: alignment of halfword and word accesses, a bounds check of stack-relative accesses against a programmable low/high window, and the handling of bus error responses for instruction fetches and data accesses. When a check fires, the block records the faulting address and a packed status word and raises an exception request to the pipeline. Choosing the vector and redirecting the pipeline are left to the pipeline itself.

Accesses arrive as a qualified beat (`acc_valid`) with no back-pressure. The checker observes and never stalls the unit, so it has no ready signal. Bus errors are single-cycle indications that carry their own address on `berr_addr`. The exception-enable bit and the two bus-exception options are plain static control levels. The outputs are registered. The request is a one-cycle pulse in the cycle after the edge at which the fault is recognised. The captured address and status word stay unchanged until the next recognised fault.

Top module: `mem_fault_check`

## Requirements
- R1: While reset is active and after it is released, `exc_req` is 0 and `fault_addr` and `fault_status` are all zeros.
- R2: The size field uses 0 for byte, 1 for halfword, and 2 or 3 for word. A valid access is misaligned when its address ANDed with the mask is nonzero. The mask is 0 for a byte, 1 for a halfword and 3 for a word, so a byte access is never misaligned.
- R3: A misaligned access always loads `fault_addr` with the access address. It also loads `fault_status` with cause 1 in bits 4..0, the destination register number in bits 9..5, the store flag in bit 10 and a word-size flag in bit 11, with all other bits 0. It raises `exc_req` only when `exc_en` is 1.
- R4: A valid access with `acc_stack` set faults when its address is below `stk_lo` or above `stk_hi`, compared as unsigned numbers. An address equal to either bound does not fault. A stack fault loads the access address and cause 7 (other status bits 0) and raises `exc_req` regardless of `exc_en`.
- R5: An instruction-bus error with `exc_en` = 1 and `cfg_ibus_exc` = 1 loads `berr_addr` and cause 4 and raises `exc_req`.
- R6: A data-bus error with `exc_en` = 1 and `cfg_dbus_exc` = 1 loads `berr_addr` and cause 3 and raises `exc_req`.
- R7: A bus error is ignored when `exc_en` is 0 or when its option bit is 0. In that case there is no request and neither `fault_addr` nor `fault_status` changes.
- R8: When several checks fire in one cycle, only the highest-priority one is recorded. The order is instruction-bus error, then data-bus error, then misalignment, then stack fault. The request follows the rule of the recorded check.
- R9: The fault registers update only on an edge where a check fires, and otherwise hold their value. `exc_req` is high for exactly one cycle per recognised fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_rd | input | RW | Destination/source register number |
| acc_stack | input | 1 | Access is stack-pointer relative |
| stk_lo | input | AW | Lowest allowed stack address |
| stk_hi | input | AW | Highest allowed stack address |
| ibus_err | input | 1 | Instruction-fetch bus error response |
| dbus_err | input | 1 | Data-access bus error response |
| berr_addr | input | AW | Address of the failing bus transaction |
| exc_en | input | 1 | Exception-enable bit |
| cfg_ibus_exc | input | 1 | Instruction-bus errors raise exceptions |
| cfg_dbus_exc | input | 1 | Data-bus errors raise exceptions |
| exc_req | output | 1 | One-cycle exception request |
| fault_addr | output | AW | Captured fault address |
| fault_status | output | SW | Captured status word |

## Verification
The bench builds the block with a 16-bit address and the default 5-bit register field and 32-bit status word. The narrow address puts the top of the address space (0xFFFF) within reach as a stack bound and as an unaligned word address, so both unsigned compare edges are exercised. The full 5-bit register field lets register 31 fill bits 9..5 completely, which exposes any slip in the packing. Every pairing of simultaneous checks that the priority order separates is driven in a single cycle.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [4:0] {
    CAUSE_NONE      = 5'd0,
    CAUSE_UNALIGNED = 5'd1,
    CAUSE_DBUS      = 5'd3,
    CAUSE_IBUS      = 5'd4,
    CAUSE_STACK     = 5'd7
  } cause_e;

  localparam int CAUSE_W   = 5;
  localparam int RD_LSB    = 5;
  localparam int STORE_BIT = 10;
  localparam int WORD_BIT  = 11;
  localparam int INFO_W    = 12;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/mfc_align_chk.sv
module mfc_align_chk
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic                acc_valid,
  input  logic [AW-1:0]       acc_addr,
  input  logic [1:0]          acc_size,
  input  logic                acc_store,
  input  logic [RW-1:0]       acc_rd,
  output logic                misal,
  output logic [INFO_W-1:0]   misal_info
);
  logic [1:0] lsb_mask;
  logic       is_word;

  always_comb begin
    is_word = acc_size[1];
    unique case (acc_size)
      SZ_BYTE: lsb_mask = 2'b00;
      SZ_HALF: lsb_mask = 2'b01;
      default: lsb_mask = 2'b11;
    endcase
    misal = acc_valid && ((acc_addr[1:0] & lsb_mask) != 2'b00);
    misal_info = '0;
    misal_info[CAUSE_W-1:0]       = CAUSE_UNALIGNED;
    misal_info[RD_LSB +: RW]      = acc_rd;
    misal_info[STORE_BIT]         = acc_store;
    misal_info[WORD_BIT]          = is_word;
  end

  // R2: a byte access can never be flagged
  always_comb begin
    if (acc_size == SZ_BYTE) a_r2_byte_never_misal: assert (!misal);
  end
endmodule

// File: rtl/mfc_stack_chk.sv
module mfc_stack_chk #(
  parameter int AW = 32
) (
  input  logic          acc_valid,
  input  logic          acc_stack,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] stk_lo,
  input  logic [AW-1:0] stk_hi,
  output logic          stk_viol
);
  logic below, above;

  always_comb begin
    below    = acc_addr < stk_lo;
    above    = acc_addr > stk_hi;
    stk_viol = acc_valid && acc_stack && (below || above);
  end

  // R4: addresses equal to a bound are inside the window
  always_comb begin
    if (acc_addr == stk_lo || acc_addr == stk_hi)
      a_r4_bound_allowed: assert (!stk_viol || (stk_lo > stk_hi));
  end
endmodule

// File: rtl/mfc_bus_chk.sv
module mfc_bus_chk (
  input  logic ibus_err,
  input  logic dbus_err,
  input  logic exc_en,
  input  logic cfg_ibus_exc,
  input  logic cfg_dbus_exc,
  output logic ibus_fire,
  output logic dbus_fire
);
  always_comb begin
    ibus_fire = exc_en && cfg_ibus_exc && ibus_err;
    dbus_fire = exc_en && cfg_dbus_exc && dbus_err;
  end

  // R7: nothing fires without the enable bit
  always_comb begin
    if (!exc_en) a_r7_bus_needs_en: assert (!ibus_fire && !dbus_fire);
  end
endmodule

// File: rtl/mem_fault_check.sv
module mem_fault_check
  import mfc_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 5,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_store,
  input  logic [RW-1:0] acc_rd,
  input  logic          acc_stack,
  input  logic [AW-1:0] stk_lo,
  input  logic [AW-1:0] stk_hi,
  input  logic          ibus_err,
  input  logic          dbus_err,
  input  logic [AW-1:0] berr_addr,
  input  logic          exc_en,
  input  logic          cfg_ibus_exc,
  input  logic          cfg_dbus_exc,
  output logic          exc_req,
  output logic [AW-1:0] fault_addr,
  output logic [SW-1:0] fault_status
);
  localparam int PAD_W = SW - INFO_W;

  logic              misal, stk_viol, ibus_fire, dbus_fire;
  logic [INFO_W-1:0] misal_info;
  logic              fire, req_d;
  logic [AW-1:0]     addr_d;
  logic [INFO_W-1:0] info_d;

  mfc_align_chk #(.AW(AW), .RW(RW)) u_align (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_store(acc_store), .acc_rd(acc_rd),
    .misal(misal), .misal_info(misal_info)
  );

  mfc_stack_chk #(.AW(AW)) u_stack (
    .acc_valid(acc_valid), .acc_stack(acc_stack), .acc_addr(acc_addr),
    .stk_lo(stk_lo), .stk_hi(stk_hi), .stk_viol(stk_viol)
  );

  mfc_bus_chk u_bus (
    .ibus_err(ibus_err), .dbus_err(dbus_err), .exc_en(exc_en),
    .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc),
    .ibus_fire(ibus_fire), .dbus_fire(dbus_fire)
  );

  // fixed priority: ibus > dbus > misalignment > stack
  always_comb begin
    fire   = 1'b1;
    req_d  = 1'b1;
    addr_d = acc_addr;
    info_d = '0;
    if (ibus_fire) begin
      addr_d = berr_addr;
      info_d[CAUSE_W-1:0] = CAUSE_IBUS;
    end else if (dbus_fire) begin
      addr_d = berr_addr;
      info_d[CAUSE_W-1:0] = CAUSE_DBUS;
    end else if (misal) begin
      info_d = misal_info;
      req_d  = exc_en;
    end else if (stk_viol) begin
      info_d[CAUSE_W-1:0] = CAUSE_STACK;
    end else begin
      fire  = 1'b0;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req      <= 1'b0;
      fault_addr   <= '0;
      fault_status <= '0;
    end else begin
      exc_req <= req_d;
      if (fire) begin
        fault_addr   <= addr_d;
        fault_status <= {{PAD_W{1'b0}}, info_d};
      end
    end
  end

  // R3: enabled misalignment (no bus error) gives a request with cause 1
  a_r3_misal_req: assert property (@(posedge clk) disable iff (!rst_n)
    (misal && exc_en && !ibus_fire && !dbus_fire) |=>
      (exc_req && fault_status[CAUSE_W-1:0] == CAUSE_UNALIGNED));

  // R3: disabled misalignment records but does not request
  a_r3_misal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (misal && !exc_en) |=> (!exc_req && fault_addr == $past(acc_addr)));

  // R4: stack fault requests even with the enable bit clear
  a_r4_stack_req: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_viol && !misal && !ibus_fire && !dbus_fire) |=>
      (exc_req && fault_status[CAUSE_W-1:0] == CAUSE_STACK));

  // R8: instruction-bus error always wins
  a_r8_ibus_first: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_fire |=> (exc_req && fault_status[CAUSE_W-1:0] == CAUSE_IBUS
                   && fault_addr == $past(berr_addr)));

  // R9: nothing fires -> registers hold and no request
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!misal && !stk_viol && !ibus_fire && !dbus_fire) |=>
      (!exc_req && $stable(fault_addr) && $stable(fault_status)));
endmodule

// File: tb/test_mem_fault_check.sv
module test_mem_fault_check;
  localparam int AW = 16;
  localparam int RW = 5;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_store = 0, acc_stack = 0;
  logic [AW-1:0] acc_addr = '0, stk_lo = '0, stk_hi = '0, berr_addr = '0;
  logic [1:0] acc_size = '0;
  logic [RW-1:0] acc_rd = '0;
  logic ibus_err = 0, dbus_err = 0, exc_en = 0, cfg_ibus_exc = 0, cfg_dbus_exc = 0;
  logic exc_req;
  logic [AW-1:0] fault_addr;
  logic [SW-1:0] fault_status;

  int ntests = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  mem_fault_check #(.AW(AW), .RW(RW), .SW(SW)) i_mem_fault_check (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_store(acc_store), .acc_rd(acc_rd),
    .acc_stack(acc_stack), .stk_lo(stk_lo), .stk_hi(stk_hi),
    .ibus_err(ibus_err), .dbus_err(dbus_err), .berr_addr(berr_addr),
    .exc_en(exc_en), .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc),
    .exc_req(exc_req), .fault_addr(fault_addr), .fault_status(fault_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mis_word(input logic [4:0] rd, input logic st, input logic wd);
    return 32'd1 | (32'(rd) << 5) | (32'(st) << 10) | (32'(wd) << 11);
  endfunction

  // present one cycle of stimulus, then sample after the edge
  task automatic step(input logic v, input logic [AW-1:0] a, input logic [1:0] sz,
                      input logic st, input logic [RW-1:0] rd, input logic stk,
                      input logic ib, input logic db, input logic [AW-1:0] ba);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_store = st; acc_rd = rd;
    acc_stack = stk; ibus_err = ib; dbus_err = db; berr_addr = ba;
    @(posedge clk);
    #1;
    acc_valid = 0; acc_stack = 0; ibus_err = 0; dbus_err = 0;
  endtask

  task automatic t_reset;
    chk("R1 req", 32'(exc_req), 0);
    chk("R1 addr", 32'(fault_addr), 0);
    chk("R1 status", fault_status, 0);
  endtask

  task automatic t_aligned;
    exc_en = 1;
    step(1, 16'h1004, 2, 0, 3, 0, 0, 0, 0);
    chk("R2 aligned word no req", 32'(exc_req), 0);
    step(1, 16'h1006, 1, 0, 3, 0, 0, 0, 0);
    chk("R2 aligned half no req", 32'(exc_req), 0);
    chk("R9 addr held", 32'(fault_addr), 0);
  endtask

  task automatic t_misal;
    exc_en = 1;
    step(1, 16'h1001, 1, 1, 7, 0, 0, 0, 0);
    chk("R3 half req", 32'(exc_req), 1);
    chk("R3 half addr", 32'(fault_addr), 32'h1001);
    chk("R3 half status", fault_status, mis_word(7, 1, 0));
    step(1, 16'hFFFE, 3, 0, 31, 0, 0, 0, 0);
    chk("R3 word status", fault_status, mis_word(31, 0, 1));
    chk("R2 word addr", 32'(fault_addr), 32'hFFFE);
    step(0, 16'h0000, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 req one cycle", 32'(exc_req), 0);
    chk("R9 status held", fault_status, mis_word(31, 0, 1));
    exc_en = 0;
    step(1, 16'h3003, 2, 1, 2, 0, 0, 0, 0);
    chk("R3 disabled no req", 32'(exc_req), 0);
    chk("R3 disabled addr", 32'(fault_addr), 32'h3003);
    chk("R3 disabled status", fault_status, mis_word(2, 1, 1));
    step(1, 16'h4005, 0, 0, 1, 0, 0, 0, 0);
    chk("R2 byte odd addr kept", 32'(fault_addr), 32'h3003);
    step(0, 16'h5003, 2, 0, 1, 0, 0, 0, 0);
    chk("R2 invalid beat ignored", 32'(fault_addr), 32'h3003);
  endtask

  task automatic t_stack;
    exc_en = 0; stk_lo = 16'h1000; stk_hi = 16'hFFFF;
    step(1, 16'h0FFC, 2, 0, 1, 1, 0, 0, 0);
    chk("R4 below req", 32'(exc_req), 1);
    chk("R4 below addr", 32'(fault_addr), 32'h0FFC);
    chk("R4 below status", fault_status, 7);
    step(1, 16'h1000, 2, 0, 1, 1, 0, 0, 0);
    chk("R4 at low bound", 32'(exc_req), 0);
    step(1, 16'hFFFF, 0, 0, 1, 1, 0, 0, 0);
    chk("R4 at high bound", 32'(exc_req), 0);
    chk("R4 bounds kept addr", 32'(fault_addr), 32'h0FFC);
    stk_hi = 16'h1FFF;
    step(1, 16'h2000, 2, 0, 1, 1, 0, 0, 0);
    chk("R4 above req", 32'(exc_req), 1);
    chk("R4 above addr", 32'(fault_addr), 32'h2000);
    step(1, 16'h0800, 2, 0, 1, 0, 0, 0, 0);
    chk("R4 non-stack ignored", 32'(exc_req), 0);
  endtask

  task automatic t_bus;
    exc_en = 1; cfg_ibus_exc = 1; cfg_dbus_exc = 1;
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'hA000);
    chk("R5 ibus req", 32'(exc_req), 1);
    chk("R5 ibus addr", 32'(fault_addr), 32'hA000);
    chk("R5 ibus status", fault_status, 4);
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'hB000);
    chk("R6 dbus req", 32'(exc_req), 1);
    chk("R6 dbus addr", 32'(fault_addr), 32'hB000);
    chk("R6 dbus status", fault_status, 3);
    cfg_ibus_exc = 0;
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'hC000);
    chk("R7 ibus opt off req", 32'(exc_req), 0);
    chk("R7 ibus opt off addr", 32'(fault_addr), 32'hB000);
    cfg_ibus_exc = 1; cfg_dbus_exc = 0;
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'hC004);
    chk("R7 dbus opt off status", fault_status, 3);
    cfg_dbus_exc = 1; exc_en = 0;
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'hD000);
    chk("R7 disabled req", 32'(exc_req), 0);
    chk("R7 disabled addr", 32'(fault_addr), 32'hB000);
    chk("R7 disabled status", fault_status, 3);
  endtask

  task automatic t_prio;
    exc_en = 1; cfg_ibus_exc = 1; cfg_dbus_exc = 1;
    stk_lo = 16'h1000; stk_hi = 16'h1FFF;
    step(1, 16'h0001, 2, 1, 4, 1, 1, 1, 16'hE000);
    chk("R8 ibus wins status", fault_status, 4);
    chk("R8 ibus wins addr", 32'(fault_addr), 32'hE000);
    step(1, 16'h0001, 2, 1, 4, 1, 0, 1, 16'hE100);
    chk("R8 dbus over misal", fault_status, 3);
    step(1, 16'h0001, 2, 1, 4, 1, 0, 0, 0);
    chk("R8 misal over stack", fault_status, mis_word(4, 1, 1));
    chk("R8 misal addr", 32'(fault_addr), 32'h0001);
    exc_en = 0;
    step(1, 16'h0003, 1, 0, 9, 1, 0, 0, 0);
    chk("R8 disabled misal masks stack req", 32'(exc_req), 0);
    chk("R8 disabled misal status", fault_status, mis_word(9, 0, 0));
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1;
    t_reset;
    t_aligned;
    t_misal;
    t_stack;
    t_bus;
    t_prio;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule